// File: doc/BRIEF.md
# Communication Loss Monitor Watchdog

This block tracks how long a field-bus slave has gone without useful traffic from its master. Only two kinds of call restart its timer: data-exchange requests and write-parameter requests that have already been decoded, found valid and found to be addressed to this slave. The upstream decoder reports each one as a single-cycle strobe. A free-running millisecond tick advances the timer. When the timer reaches its limit (41 ticks by default), the block raises a sticky no-exchange status, which the indicator logic shows to the user.

The same timer can also act as a watchdog. While the watchdog is active, every expiry also sends a one-cycle request for a full device reset, and the count starts again from zero. Two configuration flags decide whether the watchdog is active. An always-on flag turns it on permanently. A pin-enable flag hands the decision to the level of an external parameter pin. The two flags are not meant to be set together. If they are, the block keeps the watchdog on and reports a configuration error.

Top module: `comm_loss_watchdog`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `no_exchange` and `reset_req` are 0 and the tick count is zero.
- R2: A cycle with `xchg_call` or `wparm_call` high clears `no_exchange` and restarts the count from zero from the next cycle on. A call takes priority over a tick in the same cycle.
- R3: `no_exchange` goes to 1 in the cycle after the TIMEOUT_TICKS-th tick counted since the last call or reset (tick 41 by default, never tick 40). It stays at 1 until a call arrives.
- R4: When the watchdog is active, the expiring tick makes `reset_req` 1 for exactly the next cycle. Counting then restarts from zero, so the next request comes after another TIMEOUT_TICKS ticks.
- R5: When the watchdog is inactive, an expiry never raises `reset_req`. The status stays at 1 and further ticks change nothing.
- R6: The watchdog is active when `cfg_always_on` is 1. When only `cfg_pin_enable` is 1, it is active exactly while `p0_level` is 1 (high means enabled). With both flags at 0 it is inactive.
- R7: When both `cfg_always_on` and `cfg_pin_enable` are 1, the watchdog is active whatever `p0_level` is, and `cfg_error` is 1 in the same cycle. Otherwise `cfg_error` is 0.
- R8: If the watchdog becomes active while the status is already raised and no call has arrived, the next tick raises `reset_req`.
- R9: Cycles without a tick do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle millisecond tick |
| xchg_call | input | 1 | Strobe: valid addressed data-exchange call |
| wparm_call | input | 1 | Strobe: valid addressed write-parameter call |
| cfg_always_on | input | 1 | Configuration: watchdog permanently active |
| cfg_pin_enable | input | 1 | Configuration: parameter pin gates the watchdog |
| p0_level | input | 1 | Level of the gating parameter pin |
| no_exchange | output | 1 | Sticky status: no qualifying call within the timeout |
| reset_req | output | 1 | One-cycle full device reset request |
| cfg_error | output | 1 | Both configuration flags set |

## Verification
The hardest state to reach from the ports is a timer that has already expired while the watchdog was off, which is then switched on. Reaching it needs more than forty ticks with no call at all, followed by a configuration change before any call comes. The directed part of the bench builds exactly this sequence for both enable paths. The random part keeps calls rare compared with ticks, so expiries, repeated reset requests and calls that land on the expiring tick all occur many times.

// File: rtl/comm_loss_watchdog.sv
module comm_loss_watchdog #(
  parameter int TIMEOUT_TICKS = 41
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic xchg_call,
  input  logic wparm_call,
  input  logic cfg_always_on,
  input  logic cfg_pin_enable,
  input  logic p0_level,
  output logic no_exchange,
  output logic reset_req,
  output logic cfg_error
);
  // TIMEOUT_TICKS must be at least 2
  localparam int CW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);
  localparam logic [CW-1:0] FULL = CW'(TIMEOUT_TICKS);

  logic [CW-1:0] cnt;
  logic call, wd_on, expire;

  assign call      = xchg_call | wparm_call;
  assign wd_on     = cfg_always_on | (cfg_pin_enable & p0_level);
  assign cfg_error = cfg_always_on & cfg_pin_enable;
  assign expire    = tick_ms & ~call & (cnt >= LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      no_exchange <= 1'b0;
      reset_req   <= 1'b0;
    end else if (call) begin
      cnt         <= '0;
      no_exchange <= 1'b0;
      reset_req   <= 1'b0;
    end else if (expire) begin
      cnt         <= wd_on ? '0 : FULL;
      no_exchange <= 1'b1;
      reset_req   <= wd_on;
    end else begin
      if (tick_ms) cnt <= cnt + 1'b1;
      reset_req <= 1'b0;
    end
  end

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  p_call_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_call | wparm_call) |=> (!no_exchange && !reset_req));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  p_reset_with_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> no_exchange);

  p_reset_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(cfg_always_on | (cfg_pin_enable & p0_level)));

  p_status_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_exchange) |-> $past(tick_ms));

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_ms && !xchg_call && !wparm_call) |=> ($stable(cnt) && !reset_req));
endmodule

// File: tb/tb_comm_loss_watchdog.sv
module tb_comm_loss_watchdog;
  localparam int T = 41;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_ms = 0, xchg_call = 0, wparm_call = 0;
  logic cfg_always_on = 0, cfg_pin_enable = 0, p0_level = 0;
  logic no_exchange, reset_req, cfg_error;
  int n_checks = 0, n_fail = 0;
  int m_cnt = 0;
  logic m_stat = 0, m_rst = 0;

  always #4 clk = ~clk;

  comm_loss_watchdog #(.TIMEOUT_TICKS(T)) dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .xchg_call(xchg_call),
    .wparm_call(wparm_call), .cfg_always_on(cfg_always_on),
    .cfg_pin_enable(cfg_pin_enable), .p0_level(p0_level),
    .no_exchange(no_exchange), .reset_req(reset_req), .cfg_error(cfg_error));

  function automatic logic active_f(logic aon, logic pen, logic p0);
    return aon | (pen & p0);
  endfunction

  function automatic logic cerr_f(logic aon, logic pen);
    return aon & pen;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(string tag, logic tk, logic dx, logic wp);
    tick_ms = tk; xchg_call = dx; wparm_call = wp;
    @(posedge clk);
    if (dx | wp) begin
      m_cnt = 0; m_stat = 0; m_rst = 0;
    end else if (tk && m_cnt >= T - 1) begin
      m_stat = 1;
      m_rst = active_f(cfg_always_on, cfg_pin_enable, p0_level);
      m_cnt = m_rst ? 0 : T;
    end else begin
      if (tk) m_cnt++;
      m_rst = 0;
    end
    #1;
    chk({tag, " status"}, no_exchange, m_stat);
    chk({tag, " reset_req"}, reset_req, m_rst);
    chk({tag, " cfg_error"}, cfg_error, cerr_f(cfg_always_on, cfg_pin_enable));
    tick_ms = 0; xchg_call = 0; wparm_call = 0;
  endtask

  task automatic ticks(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic set_cfg(logic aon, logic pen, logic p0);
    cfg_always_on = aon; cfg_pin_enable = pen; p0_level = p0;
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 status in reset", no_exchange, 1'b0);
    chk("R1 reset_req in reset", reset_req, 1'b0);
    rst_n = 1'b1;
    cyc("R1 first cycle", 1'b0, 1'b0, 1'b0);

    // R3 boundary, watchdog off
    ticks("R3 pre", T - 1);
    chk("R3 tick 40 no status", no_exchange, 1'b0);
    ticks("R3 expiry", 1);
    chk("R3 tick 41 status", no_exchange, 1'b1);
    // R9 idle cycles and R5 saturation
    for (int i = 0; i < 5; i++) cyc("R9 idle", 1'b0, 1'b0, 1'b0);
    ticks("R5 inactive", 20);
    chk("R5 no reset_req", reset_req, 1'b0);
    chk("R5 status held", no_exchange, 1'b1);
    // R2 write-parameter call clears, call beats tick
    cyc("R2 wparm", 1'b1, 1'b0, 1'b1);
    chk("R2 cleared", no_exchange, 1'b0);
    ticks("R2 restart", T - 1);
    cyc("R2 xchg on tick", 1'b1, 1'b1, 1'b0);
    ticks("R2 restart2", T - 1);
    chk("R2 count from zero", no_exchange, 1'b0);
    for (int i = 0; i < 10; i++) cyc("R9 gap", 1'b0, 1'b0, 1'b0);
    ticks("R9 last", 1);
    chk("R9 expiry after gap", no_exchange, 1'b1);

    // R4 always-on: one pulse, repeat after T more ticks
    cyc("R2 clear", 1'b0, 1'b1, 1'b0);
    set_cfg(1, 0, 0);
    ticks("R4 pre", T);
    chk("R4 pulse", reset_req, 1'b1);
    cyc("R4 idle", 1'b0, 1'b0, 1'b0);
    chk("R4 one cycle", reset_req, 1'b0);
    ticks("R4 second", T - 1);
    chk("R4 not early", reset_req, 1'b0);
    ticks("R4 second hit", 1);
    chk("R4 second pulse", reset_req, 1'b1);

    // R6 pin mode, pin low then high
    cyc("R2 clear", 1'b0, 1'b0, 1'b1);
    set_cfg(0, 1, 0);
    ticks("R6 pin low", T);
    chk("R6 pin low no reset", reset_req, 1'b0);
    // R8 enable after status already raised
    p0_level = 1;
    cyc("R8 idle", 1'b0, 1'b0, 1'b0);
    chk("R8 no reset w/o tick", reset_req, 1'b0);
    ticks("R8 tick", 1);
    chk("R8 reset on next tick", reset_req, 1'b1);
    ticks("R6 pin high", T);
    chk("R6 pin high reset", reset_req, 1'b1);

    // R7 both flags, pin low
    cyc("R2 clear", 1'b0, 1'b1, 1'b0);
    set_cfg(1, 1, 0);
    cyc("R7 idle", 1'b0, 1'b0, 1'b0);
    chk("R7 cfg_error", cfg_error, 1'b1);
    ticks("R7 run", T);
    chk("R7 active despite pin", reset_req, 1'b1);
    set_cfg(0, 0, 1);
    cyc("R7 cleared", 1'b0, 1'b1, 1'b0);
    chk("R7 cfg_error low", cfg_error, 1'b0);

    // random phase
    for (int i = 0; i < 30000; i++) begin
      if (($urandom % 1500) == 0)
        set_cfg(1'($urandom), 1'($urandom), 1'($urandom));
      else if (($urandom % 200) == 0)
        p0_level = ~p0_level;
      cyc("RND R2 R3 R4 R5 R6 R7 R8 R9", 1'(($urandom % 4) == 0),
          1'(($urandom % 400) == 0), 1'(($urandom % 400) == 0));
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule